// File: doc/BRIEF.md
# Multicycle 16-bit Harvard Processor Core

This block is a small processor core with separate code and data memories, each holding 1024 words of 16 bits. Every instruction passes through four states: fetch, decode, execute and writeback. The instruction set covers five two-operand arithmetic and logic operations with a register or a 6-bit literal on the right, MOVE between registers, literals and register-indirect data memory, single-bit shifts with zero fill, a register jump, and six PC-relative conditional branches. Each branch compares a chosen register with R0.

A loader writes code and data words through a port while the core is held in reset. The loader then releases reset, and the core runs from address 0. While the load enable is high, the core does not advance. The only way execution ends is by decoding a word outside the defined encoding. The core then stops, raises a halted flag, and presents the offending word and its address. Two combinational read ports, one for a register and one for a data word, let the surrounding environment inspect results.

Top module: `harv_core`

## Requirements
- R1: After reset, every register R0..R15 and the PC read 0x0000, halted_o is low, bad_instr_o and bad_addr_o are 0x0000, and the first fetch is from code address 0.
- R2: With load_en_i high, load_dmem_i=0 writes load_data_i into code memory and load_dmem_i=1 writes it into data memory at load_addr_i. Data words never written read 0xFFFF. A code word of 0xFFFF is illegal, so execution stops at the first unloaded code address.
- R3: The instruction word is [15:13] family, [12:10] mode, [9:6] Rx and [5:0] operand 2. Families 000..100 are ADD, SUB, AND, OR and XOR. Mode 000 uses the sign-extended 6-bit literal as the right operand. Mode 001 uses the register in [5:2]. The result goes to Rx and wraps modulo 2^16.
- R4: In family 101, mode 000 loads the sign-extended literal into Rx. Mode 001 loads Rx from data memory at the low 10 bits of the register in [5:2].
- R5: In family 101, mode 100 stores the sign-extended literal, and mode 101 stores the register in [5:2]. Both store to data memory at the low 10 bits of Rx.
- R6: In family 110, mode 000 shifts Rx right by one bit and mode 001 shifts it left by one bit, filling with zero.
- R7: Family 111 with mode 000 (jump through a register) sets the PC to the low 10 bits of Rx.
- R8: Family 111, modes 001..110, are branches on equal, not equal, less, greater, less-or-equal and greater-or-equal. Each compares Rx with R0 as signed values. A taken branch sets the PC to its own address plus the sign-extended [5:0]. A branch that is not taken advances the PC by one.
- R9: Every instruction other than a jump or a taken branch advances the PC by exactly one.
- R10: The following combinations are illegal: family 101 with modes 010, 011, 110 or 111; family 110 with any mode other than 000 or 001; family 111 with mode 111; and families 000..100 with any mode other than 000 or 001.
- R11: A set bit in a field that must be zero makes the word illegal. These fields are [1:0] in the register modes of families 000..101, and [5:0] of a shift or a register jump.
- R12: An illegal word stops the core before it changes any register or memory. halted_o then stays high, bad_instr_o holds the word, and bad_addr_o holds its address. No later register or memory change occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_en_i | input | 1 | Load port write enable; also stalls the core |
| load_dmem_i | input | 1 | Load target: 0 code memory, 1 data memory |
| load_addr_i | input | 10 | Load word address |
| load_data_i | input | 16 | Load word |
| reg_sel_i | input | 4 | Register inspection select |
| reg_data_o | output | 16 | Selected register value |
| dmem_sel_i | input | 10 | Data memory inspection address |
| dmem_data_o | output | 16 | Data word at dmem_sel_i |
| halted_o | output | 1 | Core stopped on an illegal word |
| bad_instr_o | output | 16 | The illegal word |
| bad_addr_o | output | 16 | Code address of the illegal word |

## Verification
The hardest behaviour to observe from the ports is the outcome of each of the six branch conditions. This is hardest where a signed and an unsigned comparison would disagree, because only the final registers are visible. The stimulus loads a negative value into R0 and compares it with equal, larger positive and smaller negative registers. Before each branch it shifts R15 left, and the fall-through path sets its low bit, so a single register value records all twelve outcomes in order. The illegal encodings run one per program, each placed after a valid instruction and before one that must never take effect.

// File: rtl/harv_pkg.sv
package harv_pkg;
  localparam int ILEN   = 16;
  localparam int NREG   = 16;
  localparam int RIDX_W = 4;
  localparam int LIT_W  = 6;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SHR, ALU_SHL, ALU_PASS
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_WB, ST_HALT
  } state_e;

  typedef struct packed {
    logic       legal;
    alu_op_e    alu_op;
    logic       use_lit;
    logic       rf_we;
    logic       mem_rd;
    logic       mem_wr;
    logic       is_jr;
    logic       is_br;
    logic [2:0] br_cond;
  } dec_t;
endpackage

// File: rtl/harv_ram.sv
module harv_ram #(
  parameter int          DW    = 16,
  parameter int          DEPTH = 1024,
  parameter int          NRD   = 1,
  parameter logic [15:0] INIT  = 16'hFFFF,
  localparam int         AW    = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(INIT);
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem[raddr_i[g]];
  end
endmodule

// File: rtl/harv_regfile.sv
module harv_regfile
  import harv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RIDX_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [RIDX_W-1:0] ra_a_i,
  input  logic [RIDX_W-1:0] ra_b_i,
  input  logic [RIDX_W-1:0] ra_dbg_i,
  output logic [DW-1:0]     rd_a_o,
  output logic [DW-1:0]     rd_b_o,
  output logic [DW-1:0]     rd_r0_o,
  output logic [DW-1:0]     rd_dbg_o
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rd_a_o   = regs_q[ra_a_i];
  assign rd_b_o   = regs_q[ra_b_i];
  assign rd_r0_o  = regs_q[0];
  assign rd_dbg_o = regs_q[ra_dbg_i];
endmodule

// File: rtl/harv_decode.sv
module harv_decode
  import harv_pkg::*;
(
  input  logic [5:0]       opc_i,
  input  logic [LIT_W-1:0] op2_i,
  output dec_t             dec_o
);
  logic [2:0] fam, mode;
  logic       lo_zero, op2_zero;

  assign fam      = opc_i[5:3];
  assign mode     = opc_i[2:0];
  assign lo_zero  = (op2_i[1:0] == 2'b00);
  assign op2_zero = (op2_i == '0);

  always_comb begin
    dec_o        = '0;
    dec_o.alu_op = ALU_PASS;
    case (fam)
      3'b000, 3'b001, 3'b010, 3'b011, 3'b100: begin
        case (fam)
          3'b000:  dec_o.alu_op = ALU_ADD;
          3'b001:  dec_o.alu_op = ALU_SUB;
          3'b010:  dec_o.alu_op = ALU_AND;
          3'b011:  dec_o.alu_op = ALU_OR;
          default: dec_o.alu_op = ALU_XOR;
        endcase
        if (mode == 3'b000) begin
          dec_o.legal   = 1'b1;
          dec_o.use_lit = 1'b1;
          dec_o.rf_we   = 1'b1;
        end else if (mode == 3'b001 && lo_zero) begin
          dec_o.legal = 1'b1;
          dec_o.rf_we = 1'b1;
        end
      end
      3'b101: begin
        case (mode)
          3'b000: begin
            dec_o.legal   = 1'b1;
            dec_o.use_lit = 1'b1;
            dec_o.rf_we   = 1'b1;
          end
          3'b001: begin
            dec_o.legal  = lo_zero;
            dec_o.mem_rd = lo_zero;
            dec_o.rf_we  = lo_zero;
          end
          3'b100: begin
            dec_o.legal   = 1'b1;
            dec_o.use_lit = 1'b1;
            dec_o.mem_wr  = 1'b1;
          end
          3'b101: begin
            dec_o.legal  = lo_zero;
            dec_o.mem_wr = lo_zero;
          end
          default: dec_o.legal = 1'b0;
        endcase
      end
      3'b110: begin
        if (mode[2:1] == 2'b00 && op2_zero) begin
          dec_o.legal  = 1'b1;
          dec_o.rf_we  = 1'b1;
          dec_o.alu_op = mode[0] ? ALU_SHL : ALU_SHR;
        end
      end
      default: begin
        if (mode == 3'b000) begin
          dec_o.legal = op2_zero;
          dec_o.is_jr = op2_zero;
        end else if (mode != 3'b111) begin
          dec_o.legal   = 1'b1;
          dec_o.is_br   = 1'b1;
          dec_o.br_cond = mode;
        end
      end
    endcase
  end
endmodule

// File: rtl/harv_alu.sv
module harv_alu
  import harv_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] r0_i,
  input  logic [2:0]    cond_i,
  output logic [DW-1:0] y_o,
  output logic          taken_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_SHR: y_o = {1'b0, a_i[DW-1:1]};
      ALU_SHL: y_o = {a_i[DW-2:0], 1'b0};
      default: y_o = b_i;
    endcase
  end

  logic eq, lt;
  assign eq = (a_i == r0_i);
  assign lt = ($signed(a_i) < $signed(r0_i));

  always_comb begin
    case (cond_i)
      3'd1:    taken_o = eq;
      3'd2:    taken_o = !eq;
      3'd3:    taken_o = lt;
      3'd4:    taken_o = !lt && !eq;
      3'd5:    taken_o = lt || eq;
      3'd6:    taken_o = !lt;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/harv_core.sv
module harv_core
  import harv_pkg::*;
#(
  parameter int  DW          = 16,
  parameter int  IMEM_DEPTH  = 1024,
  parameter int  DMEM_DEPTH  = 1024,
  localparam int IAW         = $clog2(IMEM_DEPTH),
  localparam int DAW         = $clog2(DMEM_DEPTH),
  localparam int LAW         = (IAW > DAW) ? IAW : DAW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              load_dmem_i,
  input  logic [LAW-1:0]    load_addr_i,
  input  logic [DW-1:0]     load_data_i,
  input  logic [RIDX_W-1:0] reg_sel_i,
  output logic [DW-1:0]     reg_data_o,
  input  logic [DAW-1:0]    dmem_sel_i,
  output logic [DW-1:0]     dmem_data_o,
  output logic              halted_o,
  output logic [ILEN-1:0]   bad_instr_o,
  output logic [DW-1:0]     bad_addr_o
);
  state_e          state_q;
  logic [DW-1:0]   pc_q, a_q, b_q, r0_q, res_q;
  logic [ILEN-1:0] ir_q;
  logic            taken_q;
  logic [ILEN-1:0] bad_instr_q;
  logic [DW-1:0]   bad_addr_q;

  dec_t            dec;
  logic [DW-1:0]   lit_sx, rf_a, rf_b, rf_r0, alu_y, next_pc;
  logic            alu_taken, adv, rf_we, dm_core_we, is_ctrl;
  logic [DW-1:0]   imem_rdata;
  logic [1:0][DW-1:0]  dm_rdata;
  logic [1:0][DAW-1:0] dm_raddr;

  assign adv     = !load_en_i;
  assign lit_sx  = {{(DW-LIT_W){ir_q[LIT_W-1]}}, ir_q[LIT_W-1:0]};
  assign is_ctrl = dec.is_jr | dec.is_br;

  harv_decode u_dec (
    .opc_i (ir_q[15:10]),
    .op2_i (ir_q[LIT_W-1:0]),
    .dec_o (dec)
  );

  assign rf_we      = (state_q == ST_WB) && dec.rf_we && adv;
  assign dm_core_we = (state_q == ST_WB) && dec.mem_wr && adv;

  harv_regfile #(.DW(DW)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rf_we),
    .waddr_i  (ir_q[9:6]),
    .wdata_i  (res_q),
    .ra_a_i   (ir_q[9:6]),
    .ra_b_i   (ir_q[5:2]),
    .ra_dbg_i (reg_sel_i),
    .rd_a_o   (rf_a),
    .rd_b_o   (rf_b),
    .rd_r0_o  (rf_r0),
    .rd_dbg_o (reg_data_o)
  );

  harv_alu #(.DW(DW)) u_alu (
    .op_i    (dec.alu_op),
    .a_i     (a_q),
    .b_i     (b_q),
    .r0_i    (r0_q),
    .cond_i  (dec.br_cond),
    .y_o     (alu_y),
    .taken_o (alu_taken)
  );

  logic [IAW-1:0] im_raddr;
  assign im_raddr = pc_q[IAW-1:0];

  harv_ram #(.DW(DW), .DEPTH(IMEM_DEPTH), .NRD(1)) u_imem (
    .clk_i   (clk_i),
    .we_i    (load_en_i && !load_dmem_i),
    .waddr_i (load_addr_i[IAW-1:0]),
    .wdata_i (load_data_i),
    .raddr_i (im_raddr),
    .rdata_o (imem_rdata)
  );

  logic           dm_we;
  logic [DAW-1:0] dm_waddr;
  logic [DW-1:0]  dm_wdata;
  assign dm_we    = (load_en_i && load_dmem_i) || dm_core_we;
  assign dm_waddr = load_en_i ? load_addr_i[DAW-1:0] : a_q[DAW-1:0];
  assign dm_wdata = load_en_i ? load_data_i : b_q;
  assign dm_raddr = {dmem_sel_i, b_q[DAW-1:0]};

  harv_ram #(.DW(DW), .DEPTH(DMEM_DEPTH), .NRD(2)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_we),
    .waddr_i (dm_waddr),
    .wdata_i (dm_wdata),
    .raddr_i (dm_raddr),
    .rdata_o (dm_rdata)
  );
  assign dmem_data_o = dm_rdata[1];

  always_comb begin
    if (dec.is_jr)                next_pc = {{(DW-IAW){1'b0}}, a_q[IAW-1:0]};
    else if (dec.is_br && taken_q) next_pc = pc_q + lit_sx;
    else                          next_pc = pc_q + DW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_FETCH;
      pc_q        <= '0;
      ir_q        <= '0;
      a_q         <= '0;
      b_q         <= '0;
      r0_q        <= '0;
      res_q       <= '0;
      taken_q     <= 1'b0;
      bad_instr_q <= '0;
      bad_addr_q  <= '0;
    end else if (adv) begin
      case (state_q)
        ST_FETCH: begin
          ir_q    <= imem_rdata;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          if (!dec.legal) begin
            bad_instr_q <= ir_q;
            bad_addr_q  <= pc_q;
            state_q     <= ST_HALT;
          end else begin
            a_q     <= rf_a;
            b_q     <= dec.use_lit ? lit_sx : rf_b;
            r0_q    <= rf_r0;
            state_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          res_q   <= dec.mem_rd ? dm_rdata[0] : alu_y;
          taken_q <= alu_taken;
          state_q <= ST_WB;
        end
        ST_WB: begin
          pc_q    <= next_pc;
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign halted_o    = (state_q == ST_HALT);
  assign bad_instr_o = bad_instr_q;
  assign bad_addr_o  = bad_addr_q;
endmodule

// File: rtl/harv_core_chk.sv
module harv_core_chk
  import harv_pkg::*;
#(
  parameter int DW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            halted_i,
  input logic [ILEN-1:0] bad_instr_i,
  input logic [DW-1:0]   bad_addr_i,
  input state_e          state_i,
  input logic [DW-1:0]   pc_i,
  input logic [ILEN-1:0] ir_i,
  input logic            rf_we_i,
  input logic            dm_we_i,
  input logic            ctrl_i,
  input logic            stall_i
);
  assert_halt_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);

  assert_halt_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> ($stable(bad_instr_i) && $stable(bad_addr_i) && $stable(pc_i)));

  assert_halt_capture_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_i) |-> (bad_instr_i == ir_i && bad_addr_i == pc_i));

  assert_halt_no_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> (!rf_we_i && !dm_we_i));

  assert_halt_from_decode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_i) |-> $past(state_i) == ST_DECODE);

  assert_pc_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WB && !ctrl_i && !stall_i) |=> pc_i == $past(pc_i) + DW'(1));
endmodule

bind harv_core harv_core_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halted_i    (halted_o),
  .bad_instr_i (bad_instr_o),
  .bad_addr_i  (bad_addr_o),
  .state_i     (state_q),
  .pc_i        (pc_q),
  .ir_i        (ir_q),
  .rf_we_i     (rf_we),
  .dm_we_i     (dm_core_we),
  .ctrl_i      (is_ctrl),
  .stall_i     (load_en_i)
);

// File: tb/sim_harv_core.sv
module sim_harv_core;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 3000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_en_i = 1'b0;
  logic        load_dmem_i = 1'b0;
  logic [9:0]  load_addr_i = '0;
  logic [15:0] load_data_i = '0;
  logic [3:0]  reg_sel_i = '0;
  logic [15:0] reg_data_o;
  logic [9:0]  dmem_sel_i = '0;
  logic [15:0] dmem_data_o;
  logic        halted_o;
  logic [15:0] bad_instr_o, bad_addr_o;

  int checks = 0;
  int errors = 0;

  logic [15:0] pgm_w [64];
  int          pgm_a [64];
  int          pgm_n;
  logic [15:0] dat_w [8];
  int          dat_a [8];
  int          dat_n;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  harv_core u0 (
    .clk_i, .rst_ni, .load_en_i, .load_dmem_i, .load_addr_i, .load_data_i,
    .reg_sel_i, .reg_data_o, .dmem_sel_i, .dmem_data_o,
    .halted_o, .bad_instr_o, .bad_addr_o
  );

  function automatic logic [15:0] enc(int fam, int mode, int rx, int o2);
    return {fam[2:0], mode[2:0], rx[3:0], o2[5:0]};
  endfunction
  function automatic logic [15:0] lit(int fam, int rx, int v);
    return enc(fam, 0, rx, v);
  endfunction
  function automatic logic [15:0] rr(int fam, int rx, int ry);
    return enc(fam, 1, rx, ry * 4);
  endfunction
  function automatic logic [15:0] movi(int rx, int v);
    return enc(5, 0, rx, v);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(int r, logic [15:0] exp, string tag);
    reg_sel_i = r[3:0];
    #1;
    chk($sformatf("%s R[%0d]", tag, r), reg_data_o, exp);
  endtask

  task automatic chk_mem(int a, logic [15:0] exp, string tag);
    dmem_sel_i = a[9:0];
    #1;
    chk($sformatf("%s mem[%0d]", tag, a), dmem_data_o, exp);
  endtask

  task automatic put(bit dm, int a, logic [15:0] d);
    load_en_i = 1'b1; load_dmem_i = dm; load_addr_i = a[9:0]; load_data_i = d;
    @(negedge clk_i);
  endtask

  task automatic add(int a, logic [15:0] w);
    pgm_a[pgm_n] = a; pgm_w[pgm_n] = w; pgm_n++;
  endtask

  task automatic add_dat(int a, logic [15:0] w);
    dat_a[dat_n] = a; dat_w[dat_n] = w; dat_n++;
  endtask

  // hold reset, blank both memories, load, release
  task automatic start_prog();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 1024; i++) put(1'b0, i, 16'hFFFF);
    for (int i = 0; i < 1024; i++) put(1'b1, i, 16'hFFFF);
    for (int i = 0; i < pgm_n; i++) put(1'b0, pgm_a[i], pgm_w[i]);
    for (int i = 0; i < dat_n; i++) put(1'b1, dat_a[i], dat_w[i]);
    load_en_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic run(string tag);
    int cyc = 0;
    while (!halted_o && cyc < RUN_LIMIT) begin
      @(negedge clk_i);
      cyc++;
    end
    checks++;
    if (!halted_o) begin
      errors++;
      $display("FAIL %s: actual running expected halted", tag);
    end
  endtask

  task automatic clear_prog();
    pgm_n = 0; dat_n = 0;
  endtask

  task automatic t_arith();
    clear_prog();
    add(0, movi(1, 5));
    add(1, movi(2, -3));
    add(2, rr(0, 1, 2));
    add(3, lit(1, 2, 1));
    add(4, movi(3, -1));
    add(5, lit(2, 3, 15));
    add(6, lit(3, 4, -16));
    add(7, rr(4, 4, 3));
    add(8, lit(0, 4, 1));
    add(9, lit(1, 5, 31));
    add(10, rr(1, 5, 1));
    add(11, lit(4, 6, -32));
    start_prog();
    run("R3 arith");
    chk_reg(1, 16'h0002, "R3 add reg");
    chk_reg(2, 16'hFFFC, "R3 sub lit");
    chk_reg(3, 16'h000F, "R3 and lit");
    chk_reg(4, 16'h0000, "R3 or/xor/add wrap");
    chk_reg(5, 16'hFFDF, "R3 sub wrap");
    chk_reg(6, 16'hFFE0, "R3 xor min literal");
    chk("R9 stop address", bad_addr_o, 16'd12);
    chk("R2 unloaded code word", bad_instr_o, 16'hFFFF);
  endtask

  task automatic t_reset();
    clear_prog();
    start_prog();
    chk("R1 halted low", {15'd0, halted_o}, 16'd0);
    chk("R1 bad_instr", bad_instr_o, 16'd0);
    chk("R1 bad_addr", bad_addr_o, 16'd0);
    for (int r = 0; r < 16; r++) chk_reg(r, 16'h0000, "R1 reg reset");
    run("R2 empty code");
    chk("R2 halt at 0 addr", bad_addr_o, 16'd0);
    chk("R2 halt at 0 word", bad_instr_o, 16'hFFFF);
  endtask

  task automatic t_move();
    clear_prog();
    add_dat(10, 16'h1234);
    add(0, movi(1, 10));
    add(1, enc(5, 1, 2, 1 * 4));
    add(2, movi(5, 20));
    add(3, enc(5, 4, 5, -2));
    add(4, movi(6, 21));
    add(5, enc(5, 5, 6, 2 * 4));
    add(6, movi(7, 30));
    add(7, enc(5, 1, 8, 7 * 4));
    add(8, movi(9, -1));
    add(9, enc(5, 4, 9, 7));
    add(10, enc(5, 1, 10, 9 * 4));
    start_prog();
    run("R4 move");
    chk_reg(2, 16'h1234, "R4 load indirect");
    chk_reg(8, 16'hFFFF, "R2 unloaded data");
    chk_reg(10, 16'h0007, "R4 load after store");
    chk_mem(20, 16'hFFFE, "R5 store literal");
    chk_mem(21, 16'h1234, "R5 store register");
    chk_mem(1023, 16'h0007, "R5 low 10 address bits");
    chk_mem(10, 16'h1234, "R2 data load port");
    chk("R9 stop address", bad_addr_o, 16'd11);
  endtask

  task automatic t_shift();
    clear_prog();
    add(0, movi(1, -1));
    add(1, enc(6, 0, 1, 0));
    add(2, movi(2, -16));
    add(3, enc(6, 1, 2, 0));
    add(4, movi(3, 1));
    add(5, enc(6, 0, 3, 0));
    add(6, movi(4, -32));
    add(7, enc(6, 0, 4, 0));
    add(8, enc(6, 0, 4, 0));
    start_prog();
    run("R6 shift");
    chk_reg(1, 16'h7FFF, "R6 right zero fill");
    chk_reg(2, 16'hFFE0, "R6 left");
    chk_reg(3, 16'h0000, "R6 right out");
    chk_reg(4, 16'h3FF8, "R6 right twice");
  endtask

  task automatic t_jr();
    clear_prog();
    add(0, movi(1, 5));
    add(1, enc(7, 0, 1, 0));
    add(2, movi(2, 1));
    add(5, movi(3, 9));
    start_prog();
    run("R7 jr");
    chk_reg(2, 16'h0000, "R7 skipped");
    chk_reg(3, 16'h0009, "R7 target executed");
    chk("R7 stop address", bad_addr_o, 16'd6);
    clear_prog();
    add(0, movi(1, -1));
    add(1, enc(7, 0, 1, 0));
    start_prog();
    run("R7 jr low bits");
    chk("R7 low 10 bits of target", bad_addr_o, 16'h03FF);
  endtask

  task automatic t_branch();
    int cc [12] = '{1, 1, 2, 2, 3, 3, 4, 4, 5, 6, 6, 5};
    int rx [12] = '{1, 2, 2, 1, 3, 2, 2, 1, 1, 3, 1, 2};
    clear_prog();
    add(0, movi(0, -2));
    add(1, movi(1, -2));
    add(2, movi(2, 3));
    add(3, movi(3, -5));
    for (int k = 0; k < 12; k++) begin
      add(4 + 3*k, enc(6, 1, 15, 0));
      add(5 + 3*k, enc(7, cc[k], rx[k], 2));
      add(6 + 3*k, lit(0, 15, 1));
    end
    start_prog();
    run("R8 branch set");
    // bit set = fall-through; pairs taken/not-taken per condition, signed
    chk_reg(15, 16'h0555, "R8 branch outcomes");
    chk("R8 stop address", bad_addr_o, 16'd40);
  endtask

  task automatic t_loop();
    clear_prog();
    add(0, movi(4, 3));
    add(1, lit(0, 6, 2));
    add(2, lit(1, 4, 1));
    add(3, enc(7, 2, 4, -2));
    add(4, enc(7, 1, 7, 31));
    add(5, movi(8, 1));
    add(35, movi(9, 7));
    start_prog();
    run("R8 loop");
    chk_reg(6, 16'h0006, "R8 backward branch");
    chk_reg(4, 16'h0000, "R8 loop counter");
    chk_reg(8, 16'h0000, "R8 forward skip");
    chk_reg(9, 16'h0007, "R8 max offset target");
    chk("R8 stop address", bad_addr_o, 16'd36);
  endtask

  task automatic t_illegal(logic [15:0] w, string tag);
    clear_prog();
    add(0, movi(1, 1));
    add(1, w);
    add(2, movi(2, 1));
    start_prog();
    run(tag);
    chk({tag, " word"}, bad_instr_o, w);
    chk({tag, " addr"}, bad_addr_o, 16'd1);
    chk_reg(1, 16'h0001, tag);
    repeat (20) @(negedge clk_i);
    chk({"R12 still halted ", tag}, {15'd0, halted_o}, 16'd1);
    chk_reg(2, 16'h0000, {"R12 no later effect ", tag});
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_arith();
    t_reset();
    t_move();
    t_shift();
    t_jr();
    t_branch();
    t_loop();
    t_illegal(enc(5, 2, 1, 0), "R10 move mode 010");
    t_illegal(enc(5, 3, 1, 0), "R10 move mode 011");
    t_illegal(enc(5, 6, 1, 0), "R10 move mode 110");
    t_illegal(enc(5, 7, 1, 0), "R10 move mode 111");
    t_illegal(enc(6, 2, 1, 0), "R10 shift mode 010");
    t_illegal(enc(7, 7, 1, 0), "R10 flow mode 111");
    t_illegal(enc(0, 2, 1, 0), "R10 arith mode 010");
    t_illegal(enc(0, 1, 1, 5), "R11 reg mode low bits");
    t_illegal(enc(5, 1, 1, 6), "R11 load low bits");
    t_illegal(enc(6, 0, 1, 1), "R11 shift operand");
    t_illegal(enc(7, 0, 1, 4), "R11 jr operand");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule